// File: doc/BRIEF.md
# AES-128 Round-Key Scheduler with Key Reuse

This block expands a 128-bit AES cipher key into the eleven round keys of AES-128. It keeps all of them in a register array that a cipher datapath reads through a combinational index port. A decryption datapath typically walks that port from index 10 down to index 0.

The expansion is sequential and produces one derived key per clock. When a new key is presented with `load_i`, the block first checks whether the full schedule is already valid for that exact key. If it is, the request costs nothing: the stored keys are kept and `ready_o` never drops. Any other load writes the new key into slot 0, clears the derived slots and starts the expansion again. This also applies to a load that arrives while an expansion is still running.

Every state change happens on the rising clock edge. The load request is an ordinary synchronous input, and only reset is asynchronous.

Top module: `aes_key_sched_reuse`

## Requirements
- R1: While reset is asserted and after its release, `ready_o` is low and every slot from 0 to 10 reads as zero.
- R2: A load that is not a reuse hit does three things on its clock edge: it writes `key_i` into slot 0, clears slots 1 to 10 to zero, and brings `ready_o` low from the following cycle.
- R3: Exactly one derived key is written per clock. After k rising edges that follow the load edge, slots 1..k hold their keys and slots k+1..10 read zero. `ready_o` rises on the 10th edge after the load edge.
- R4: Slot n (1..10) equals the AES-128 schedule step applied to slot n-1. The step is: rotate the last word left by one byte, pass each byte through the AES S-box, XOR the round constant into the top byte, then chain the XORs across the four words. The round constants for n=1..10 are 01,02,04,08,10,20,40,80,1B,36. Word 0 of a key is bits 127:96 and word 3 is bits 31:0.
- R5: A load while `ready_o` is high whose key equals slot 0 changes no slot, and `ready_o` stays high.
- R6: The first load after reset always regenerates the schedule, even for the all-zero key that matches the reset contents of slot 0.
- R7: A load during an expansion aborts it and restarts from the new key, even when that key equals slot 0. `ready_o` then rises 10 edges after the second load edge.
- R8: `rd_key_o` shows the slot addressed by `rd_idx_i` in the same cycle. Indices 11 to 15 return zero.
- R9: `ready_o` is high only while all eleven slots are valid, and it stays high until the next load that is not a reuse hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Synchronous request to install `key_i` |
| key_i | input | 128 | Cipher key, word 0 in bits 127:96 |
| ready_o | output | 1 | All eleven round keys valid |
| rd_idx_i | input | 4 | Round-key slot to read |
| rd_key_o | output | 128 | Contents of the addressed slot |

## Verification
The bench builds the block with its default parameters: ten rounds, 128-bit keys and the reuse check enabled. With that setting it can sweep every intermediate point of an expansion, slot by slot, and every read index, including the five indices past the store. The expected schedules come from an S-box that the bench derives by brute-force field inversion. That schedule is anchored to the published key-expansion vector and to the all-zero key. Abort timing is distinguished from undisturbed expansion by the cycle in which ready rises.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;

   // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] xtime(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc, aa;
      acc = 8'h00;
      aa  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ aa;
         aa = xtime(aa);
      end
      return acc;
   endfunction

   // Multiplicative inverse as a^254; zero maps to zero
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r, p;
      r = 8'h01;
      p = a;
      for (int i = 0; i < 8; i++) begin
         if (i != 0) r = gf_mul(r, p);
         p = gf_mul(p, p);
      end
      return r;
   endfunction

   function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
      logic [7:0] b;
      b = gf_inv(x);
      return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
               ^ {b[3:0], b[7:4]} ^ 8'h63;
   endfunction

   // Round constant for step r (r >= 1)
   function automatic logic [7:0] rcon(input int unsigned r);
      logic [7:0] v;
      v = 8'h01;
      for (int k = 1; k < 16; k++)
         if (k < r) v = xtime(v);
      return v;
   endfunction

endpackage

// File: rtl/aes_ks_sbox.sv
module aes_ks_sbox (
   input  logic [7:0] in_i,
   output logic [7:0] out_o
);
   always_comb out_o = aes_ks_pkg::sbox_fwd(in_i);
endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step #(
   parameter int unsigned KEY_W  = 128,
   parameter int unsigned WORD_W = 32
) (
   input  logic [KEY_W-1:0]  prev_i,
   input  logic [7:0]        rcon_i,
   output logic [KEY_W-1:0]  next_o
);
   localparam int unsigned NWORDS = KEY_W / WORD_W;
   localparam int unsigned NBYTES = WORD_W / 8;

   logic [WORD_W-1:0] last_w, rot_w, sub_w, mix_w;

   assign last_w = prev_i[WORD_W-1:0];
   assign rot_w  = {last_w[WORD_W-9:0], last_w[WORD_W-1:WORD_W-8]};

   for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      aes_ks_sbox u_sbox (
         .in_i  (rot_w[b*8 +: 8]),
         .out_o (sub_w[b*8 +: 8])
      );
   end

   assign mix_w = sub_w ^ {rcon_i, {(WORD_W-8){1'b0}}};

   // word 0 sits in the most significant bits
   logic [WORD_W-1:0] chain [NWORDS+1];
   assign chain[0] = mix_w;
   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam int unsigned HI = KEY_W - 1 - w*WORD_W;
      assign chain[w+1] = chain[w] ^ prev_i[HI -: WORD_W];
      assign next_o[HI -: WORD_W] = chain[w+1];
   end
endmodule

// File: rtl/aes_ks_store.sv
module aes_ks_store #(
   parameter int unsigned KEY_W = 128,
   parameter int unsigned DEPTH = 11,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [KEY_W-1:0] key_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [KEY_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0] src_idx_i,
   output logic [KEY_W-1:0] src_data_o,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [KEY_W-1:0] rd_data_o,
   output logic [KEY_W-1:0] slot0_o,
   output logic             all_valid_o
);
   logic [KEY_W-1:0] mem_q   [DEPTH];
   logic [DEPTH-1:0] valid_q;

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            mem_q[s]   <= '0;
            valid_q[s] <= 1'b0;
         end else if (restart_i) begin
            mem_q[s]   <= (s == 0) ? key_i : '0;
            valid_q[s] <= (s == 0);
         end else if (wr_en_i && wr_idx_i == IDX_W'(s)) begin
            mem_q[s]   <= wr_data_i;
            valid_q[s] <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_data_o  = '0;
      src_data_o = '0;
      for (int s = 0; s < DEPTH; s++) begin
         if (rd_idx_i == IDX_W'(s))  rd_data_o  = mem_q[s];
         if (src_idx_i == IDX_W'(s)) src_data_o = mem_q[s];
      end
   end

   assign slot0_o     = mem_q[0];
   assign all_valid_o = &valid_q;
endmodule

// File: rtl/aes_key_sched_reuse.sv
module aes_key_sched_reuse #(
   parameter int unsigned KEY_W      = 128,
   parameter int unsigned NUM_ROUNDS = 10,
   parameter bit          REUSE_EN   = 1'b1,
   localparam int unsigned DEPTH     = NUM_ROUNDS + 1,
   localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [KEY_W-1:0] key_i,
   output logic             ready_o,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [KEY_W-1:0] rd_key_o
);
   localparam int unsigned WORD_W = 32;

   if (KEY_W != 128) begin : g_bad_width
      $error("aes_key_sched_reuse: KEY_W must be 128");
   end
   if (NUM_ROUNDS != 10) begin : g_bad_rounds
      $error("aes_key_sched_reuse: NUM_ROUNDS must be 10 for a 128-bit key");
   end

   logic             busy_q;
   logic [IDX_W-1:0] rnd_q;
   logic [KEY_W-1:0] slot0_w, src_w, next_w;
   logic             all_valid_w, hit_w, restart_w, step_we_w;
   logic [7:0]       rcon_w;

   // Reuse check variant
   if (REUSE_EN) begin : g_reuse
      assign hit_w = all_valid_w && (key_i == slot0_w);
   end else begin : g_noreuse
      assign hit_w = 1'b0;
   end

   assign restart_w = load_i && !hit_w;
   assign step_we_w = busy_q && !restart_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         rnd_q  <= '0;
      end else if (restart_w) begin
         busy_q <= 1'b1;
         rnd_q  <= IDX_W'(1);
      end else if (busy_q) begin
         if (rnd_q == IDX_W'(NUM_ROUNDS)) begin
            busy_q <= 1'b0;
            rnd_q  <= '0;
         end else begin
            rnd_q  <= rnd_q + IDX_W'(1);
         end
      end
   end

   assign rcon_w = aes_ks_pkg::rcon(int'(rnd_q));

   aes_ks_step #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_step (
      .prev_i (src_w),
      .rcon_i (rcon_w),
      .next_o (next_w)
   );

   aes_ks_store #(.KEY_W(KEY_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .restart_i   (restart_w),
      .key_i       (key_i),
      .wr_en_i     (step_we_w),
      .wr_idx_i    (rnd_q),
      .wr_data_i   (next_w),
      .src_idx_i   (rnd_q - IDX_W'(1)),
      .src_data_o  (src_w),
      .rd_idx_i    (rd_idx_i),
      .rd_data_o   (rd_key_o),
      .slot0_o     (slot0_w),
      .all_valid_o (all_valid_w)
   );

   assign ready_o = all_valid_w;
endmodule

// File: rtl/aes_key_sched_reuse_chk.sv
module aes_key_sched_reuse_chk #(
   parameter int unsigned KEY_W      = 128,
   parameter int unsigned NUM_ROUNDS = 10,
   parameter int unsigned IDX_W      = 4,
   parameter bit          REUSE_EN   = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             load_i,
   input logic [KEY_W-1:0] key_i,
   input logic             ready_o,
   input logic [KEY_W-1:0] slot0_i,
   input logic             busy_i,
   input logic [IDX_W-1:0] rnd_i
);
   if (REUSE_EN) begin : g_reuse_chk
      assert_reuse_keeps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (load_i && ready_o && key_i == slot0_i) |=> (ready_o && slot0_i == $past(slot0_i)));
   end

   assert_miss_restarts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !(REUSE_EN && ready_o && key_i == slot0_i))
         |=> (!ready_o && slot0_i == $past(key_i)));

   assert_one_per_clock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && !load_i && rnd_i != IDX_W'(NUM_ROUNDS))
         |=> (busy_i && (rnd_i - $past(rnd_i)) == IDX_W'(1)));

   assert_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && load_i) |=> (busy_i && rnd_i == IDX_W'(1)));

   assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> !busy_i);

   assert_ready_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> ($past(busy_i) && !$past(load_i)));
endmodule

bind aes_key_sched_reuse aes_key_sched_reuse_chk #(
   .KEY_W(KEY_W), .NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W), .REUSE_EN(REUSE_EN)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .load_i  (load_i),
   .key_i   (key_i),
   .ready_o (ready_o),
   .slot0_i (slot0_w),
   .busy_i  (busy_q),
   .rnd_i   (rnd_q)
);

// File: tb/tb_aes_key_sched_reuse.sv
module tb_aes_key_sched_reuse;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load = 1'b0;
   logic [127:0] key = '0;
   logic [3:0]   rd_idx = '0;
   logic         ready;
   logic [127:0] rd_key;

   int checks = 0;
   int errors = 0;

   logic [7:0]   sb [256];
   logic [127:0] mk [11];

   always #10 clk = ~clk;

   aes_key_sched_reuse dut (
      .clk_i(clk), .rst_ni(rst_n), .load_i(load), .key_i(key),
      .ready_o(ready), .rd_idx_i(rd_idx), .rd_key_o(rd_key)
   );

   function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
      logic [15:0] p = '0;
      for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
      for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
      return p[7:0];
   endfunction

   function automatic logic [7:0] make_sbox(input logic [7:0] x);
      logic [7:0] inv = 8'h00, s;
      for (int c = 1; c < 256; c++) if (x != 0 && mul(x, 8'(c)) == 8'h01) inv = 8'(c);
      for (int i = 0; i < 8; i++)
         s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
      return s ^ 8'h63;
   endfunction

   task automatic build(input logic [127:0] k);
      logic [7:0] rc [10] = '{8'h01,8'h02,8'h04,8'h08,8'h10,8'h20,8'h40,8'h80,8'h1b,8'h36};
      logic [31:0] w [44];
      logic [31:0] t;
      for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         t = w[i-1];
         if (i % 4 == 0) begin
            t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
            t[31:24] = t[31:24] ^ rc[i/4 - 1];
         end
         w[i] = w[i-4] ^ t;
      end
      for (int n = 0; n < 11; n++) mk[n] = {w[4*n], w[4*n+1], w[4*n+2], w[4*n+3]};
   endtask

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input int idx, output logic [127:0] v);
      rd_idx = 4'(idx);
      #1 v = rd_key;
   endtask

   task automatic do_load(input logic [127:0] k);
      @(negedge clk); load = 1'b1; key = k;
      @(negedge clk); load = 1'b0;
   endtask

   task automatic all_slots(input string tag);
      logic [127:0] v;
      for (int n = 10; n >= 0; n--) begin
         rd(n, v);
         chk(tag, v, mk[n]);
      end
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [127:0] v, z;
      logic [127:0] kf = 128'h2b7e151628aed2a6abf7158809cf4f3c;
      logic [127:0] k2 = 128'h000102030405060708090a0b0c0d0e0f;
      logic [127:0] k3 = 128'hffeeddccbbaa99887766554433221100;
      logic [127:0] k4 = 128'h0123456789abcdeffedcba9876543210;
      z = '0;
      for (int i = 0; i < 256; i++) sb[i] = make_sbox(8'(i));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", 128'(ready), 128'(0));
      @(negedge clk); rst_n = 1'b1;
      #1 chk("R1 ready after reset", 128'(ready), 128'(0));
      for (int n = 0; n < 16; n++) begin rd(n, v); chk("R1 slot zero", v, z); end

      // R6 + R3: zero key right after reset must expand, one slot per clock
      build(z);
      do_load(z);
      #1 chk("R6 ready low after first load", 128'(ready), 128'(0));
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         rd(k, v); chk("R3 slot written", v, mk[k]);
         if (k < 10) begin rd(k + 1, v); chk("R3 next slot still zero", v, z); end
         chk("R3 ready timing", 128'(ready), 128'(k == 10));
      end
      rd(1, v); chk("R4 zero key round 1", v, 128'h62636363626363636263636362636363);
      all_slots("R4 zero key schedule");

      // R4: published vector
      build(kf);
      do_load(kf);
      repeat (10) @(negedge clk);
      chk("R9 ready after expansion", 128'(ready), 128'(1));
      rd(1, v);  chk("R4 vector round 1", v, 128'ha0fafe1788542cb123a339392a6c7605);
      rd(10, v); chk("R4 vector round 10", v, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
      all_slots("R4 vector schedule");

      // R5: reuse hit keeps everything
      do_load(kf);
      #1 chk("R5 ready stays high", 128'(ready), 128'(1));
      repeat (3) @(negedge clk);
      chk("R5 ready still high", 128'(ready), 128'(1));
      all_slots("R5 slots unchanged");

      // R2: a different key restarts
      build(k2);
      do_load(k2);
      #1 chk("R2 ready drops", 128'(ready), 128'(0));
      rd(0, v);  chk("R2 slot0 holds key", v, k2);
      rd(10, v); chk("R2 slot10 cleared", v, z);
      repeat (10) @(negedge clk);
      all_slots("R2 new schedule");

      // R7: abort with another key
      do_load(k3);
      repeat (3) @(negedge clk);
      build(k4);
      do_load(k4);
      repeat (9) @(negedge clk);
      #1 chk("R7 ready low at 9", 128'(ready), 128'(0));
      @(negedge clk);
      #1 chk("R7 ready high at 10", 128'(ready), 128'(1));
      all_slots("R7 aborted schedule");

      // R7: repeat same key mid-expansion still restarts
      build(k3);
      do_load(k3);
      repeat (3) @(negedge clk);
      do_load(k3);
      repeat (6) @(negedge clk);
      #1 chk("R7 same key restart, not early", 128'(ready), 128'(0));
      repeat (3) @(negedge clk);
      #1 chk("R7 same key restart low at 9", 128'(ready), 128'(0));
      @(negedge clk);
      #1 chk("R7 same key restart high", 128'(ready), 128'(1));
      all_slots("R7 same key schedule");

      // R8: out-of-range indices
      for (int n = 11; n < 16; n++) begin rd(n, v); chk("R8 index past store", v, z); end

      // R9: ready holds while idle
      repeat (20) @(negedge clk);
      #1 chk("R9 ready holds idle", 128'(ready), 128'(1));

      summary();
   end
endmodule